// File: doc/BRIEF.md
# Pulse-Count LED Level Programmer

This block sets the brightness of a current-mode LED boost driver from two wires. An active-low select input marks a programming frame. While the frame is open, each rising edge on a pulse input moves a single token one step along a seven-stage one-hot register. When select is released, the stage that holds the token is copied into an output latch. That latch is given out as a 3-bit step code. Step n asks the analog stage for a peak current of (n + 0.5) times its reference scale, so step 7 is the maximum of 7.5. If the frame ends with no pulses, or with more pulses than there are stages, the register is empty and the driver shuts down.

A strapped mode input selects between counted programming (high, the default when the pin is left open) and direct switching (low). In direct mode the pulse input has no effect. Select low gives the full-scale step and select high gives zero, so a PWM signal on select dims the LEDs. Whenever the step code is nonzero the converter-enable output is high. A settling timer raises a settled flag a fixed number of system clock cycles after the converter is switched on. All three inputs are asynchronous and pass through two-flop synchronizers before any logic uses them.

Top module: `pulse_level_prog`

## Requirements
- R1: After a synchronous reset the step code is 0 and both the converter-enable and the settled outputs are low.
- R2: In counted mode, a select frame that holds n rising edges on the pulse input, with n from 1 to 7, sets the step code to n when select rises. Each new frame starts from an empty register.
- R3: A frame with more pulses than N_STEPS (8 or more by default) yields step code 0 and drops converter-enable.
- R4: In counted mode the step code changes only when select is released. Pulses inside an open frame, and pulses while select is high, leave the outputs unchanged.
- R5: Converter-enable is high exactly when the step code is nonzero.
- R6: The settled flag rises SETTLE_CYCLES+1 system clocks after converter-enable rises. It falls one clock after converter-enable falls. A change from one nonzero step to another does not restart the timer.
- R7: With the mode input low, the pulse input is ignored. Select low drives the step code to 7 (N_STEPS) and select high drives it to 0.
- R8: A select release driven just before a system clock edge appears on the step code after the third rising system clock edge.
- R9: A frame with no pulses yields step code 0, which is shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Asynchronous active-low frame select; in direct mode, the on/off control |
| pulse_i | input | 1 | Asynchronous programming pulse input; rising edges count |
| prog_mode_i | input | 1 | Mode strap: 1 = counted programming, 0 = direct on/off |
| step_code_o | output | 3 | Latched current step, 0 (off) to 7 |
| conv_en_o | output | 1 | Converter enable, high for any nonzero step |
| settled_o | output | 1 | High once the settling delay has run out after enable |

## Verification
A misplaced or duplicated token in the shift register does not show at the ports during the frame. It shows only at the next select release, as a wrong step code three clocks after the release, and as a wrong converter-enable in the same cycle. A wrong down-counter load, or a missed restart in the settling timer, shows as the settled flag rising early or late compared with a model that counts how long converter-enable has been high without a break. Every clock compares all three outputs with a behavioural model, so a fault shows within one cycle of the first step where the design and the model disagree.

// File: rtl/plp_pkg.sv
package plp_pkg;

    typedef struct packed {
        logic prog_mode;
        logic sel_lvl;
        logic sel_rise;
        logic sel_fall;
        logic pulse_rise;
    } plp_ctrl_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_DIRECT_ON,
        OP_DIRECT_OFF,
        OP_CAPTURE,
        OP_ARM,
        OP_SHIFT
    } plp_op_t;

    localparam int IX_SEL   = 0;
    localparam int IX_PULSE = 1;
    localparam int IX_MODE  = 2;
    localparam int N_IN     = 3;

    // Capture has priority over arm, and arm over shift; direct mode overrides all.
    function automatic plp_op_t decode_op(input plp_ctrl_t c);
        plp_op_t op;
        if (!c.prog_mode)
            op = c.sel_lvl ? OP_DIRECT_OFF : OP_DIRECT_ON;
        else if (c.sel_rise)
            op = OP_CAPTURE;
        else if (c.sel_fall)
            op = OP_ARM;
        else if (c.pulse_rise && !c.sel_lvl)
            op = OP_SHIFT;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/plp_sync.sv
module plp_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign lvl[i]  = sync_q[i];
        assign rise[i] = sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] & prev_q[i];
    end
endmodule

// File: rtl/plp_token_shift.sv
module plp_token_shift
    import plp_pkg::*;
#(
    parameter int N_STEPS = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  plp_op_t            op,
    output logic [N_STEPS-1:0] stages,
    output logic [N_STEPS-1:0] latch_oh
);
    localparam logic [N_STEPS-1:0] FULL_OH = {1'b1, {(N_STEPS-1){1'b0}}};

    logic token_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            token_q  <= 1'b0;
            stages   <= '0;
            latch_oh <= '0;
        end else begin
            unique case (op)
                OP_DIRECT_ON: begin
                    token_q  <= 1'b0;
                    stages   <= '0;
                    latch_oh <= FULL_OH;
                end
                OP_DIRECT_OFF: begin
                    token_q  <= 1'b0;
                    stages   <= '0;
                    latch_oh <= '0;
                end
                OP_CAPTURE: begin
                    latch_oh <= stages;
                    stages   <= '0;
                    token_q  <= 1'b0;
                end
                OP_ARM: begin
                    stages  <= '0;
                    token_q <= 1'b1;
                end
                OP_SHIFT: begin
                    stages  <= {stages[N_STEPS-2:0], token_q};
                    token_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/plp_encode.sv
module plp_encode #(
    parameter int N_STEPS = 7,
    parameter int CODE_W  = 3
) (
    input  logic [N_STEPS-1:0] onehot,
    output logic [CODE_W-1:0]  code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < N_STEPS; i++) begin
            if (onehot[i])
                code = code | CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/plp_settle_timer.sv
module plp_settle_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic settled
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            en_q    <= 1'b0;
            settled <= 1'b0;
        end else begin
            en_q <= en;
            if (!en) begin
                cnt_q   <= '0;
                settled <= 1'b0;
            end else if (!en_q) begin
                cnt_q   <= CNT_W'(CYCLES);
                settled <= 1'b0;
            end else if (cnt_q > CNT_W'(1)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (cnt_q == CNT_W'(1)) begin
                cnt_q   <= '0;
                settled <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_level_prog.sv
module pulse_level_prog
    import plp_pkg::*;
#(
    parameter int N_STEPS       = 7,
    parameter int SETTLE_CYCLES = 10000,
    parameter int CODE_W        = $clog2(N_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_i,
    input  logic              pulse_i,
    input  logic              prog_mode_i,
    output logic [CODE_W-1:0] step_code_o,
    output logic              conv_en_o,
    output logic              settled_o
);
    localparam logic [N_IN-1:0] IN_RST = 3'b101;

    logic [N_IN-1:0]    raw_in;
    logic [N_IN-1:0]    lvl_s;
    logic [N_IN-1:0]    rise_s;
    logic [N_IN-1:0]    fall_s;
    plp_ctrl_t          ctrl;
    plp_op_t            op;
    logic               prog_mode_s;
    logic               sel_lvl_s;
    logic               sel_rise_s;
    logic [N_STEPS-1:0] stages_s;
    logic [N_STEPS-1:0] latch_oh;

    always_comb begin
        raw_in           = '0;
        raw_in[IX_SEL]   = sel_n_i;
        raw_in[IX_PULSE] = pulse_i;
        raw_in[IX_MODE]  = prog_mode_i;
    end

    plp_sync #(.W(N_IN), .RST_VAL(IN_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .lvl  (lvl_s),
        .rise (rise_s),
        .fall (fall_s)
    );

    assign prog_mode_s = lvl_s[IX_MODE];
    assign sel_lvl_s   = lvl_s[IX_SEL];
    assign sel_rise_s  = rise_s[IX_SEL];

    always_comb begin
        ctrl.prog_mode  = prog_mode_s;
        ctrl.sel_lvl    = sel_lvl_s;
        ctrl.sel_rise   = sel_rise_s;
        ctrl.sel_fall   = fall_s[IX_SEL];
        ctrl.pulse_rise = rise_s[IX_PULSE];
        op              = decode_op(ctrl);
    end

    plp_token_shift #(.N_STEPS(N_STEPS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .stages   (stages_s),
        .latch_oh (latch_oh)
    );

    plp_encode #(.N_STEPS(N_STEPS), .CODE_W(CODE_W)) u_enc (
        .onehot (latch_oh),
        .code   (step_code_o)
    );

    assign conv_en_o = |latch_oh;

    plp_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .en      (conv_en_o),
        .settled (settled_o)
    );
endmodule

// File: rtl/plp_checker.sv
module plp_checker #(
    parameter int N_STEPS = 7,
    parameter int CODE_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               prog_mode,
    input logic               sel_lvl,
    input logic               sel_rise,
    input logic [N_STEPS-1:0] stages,
    input logic [CODE_W-1:0]  step_code,
    input logic               conv_en,
    input logic               settled
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (step_code == '0 && !settled)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) $onehot0(stages)); // R3
    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (rst) (prog_mode && !sel_rise) |=> $stable(step_code)); // R4
    AST_EN_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst) conv_en == (step_code != '0)); // R5
    AST_SETTLE_DROPS: assert property (@(posedge clk) disable iff (rst) !conv_en |=> !settled); // R6
    AST_SETTLE_NOT_EARLY: assert property (@(posedge clk) disable iff (rst) $rose(conv_en) |=> !settled); // R6
    AST_DIRECT_FULL: assert property (@(posedge clk) disable iff (rst) (!prog_mode && !sel_lvl) |=> step_code == CODE_W'(N_STEPS)); // R7
    AST_DIRECT_OFF: assert property (@(posedge clk) disable iff (rst) (!prog_mode && sel_lvl) |=> step_code == '0); // R7
endmodule

bind pulse_level_prog plp_checker #(.N_STEPS(N_STEPS), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .prog_mode (prog_mode_s),
    .sel_lvl   (sel_lvl_s),
    .sel_rise  (sel_rise_s),
    .stages    (stages_s),
    .step_code (step_code_o),
    .conv_en   (conv_en_o),
    .settled   (settled_o)
);

// File: tb/pulse_level_prog_tb_top.sv
`timescale 1ns/1ps
module pulse_level_prog_tb_top;
    localparam int S = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       pulse = 1'b0;
    logic       mode = 1'b1;
    logic [2:0] code;
    logic       en;
    logic       settled;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pulse_level_prog #(.N_STEPS(7), .SETTLE_CYCLES(S)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .sel_n_i     (sel_n),
        .pulse_i     (pulse),
        .prog_mode_i (mode),
        .step_code_o (code),
        .conv_en_o   (en),
        .settled_o   (settled)
    );

    // Behavioural reference: input history queues, token position, run length.
    bit sel_h[$];
    bit pul_h[$];
    bit mod_h[$];
    int tok_pos = -1;
    int m_level = 0;
    int en_run  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            sel_h = '{1'b1, 1'b1, 1'b1};
            pul_h = '{1'b0, 1'b0, 1'b0};
            mod_h = '{1'b1, 1'b1, 1'b1};
            tok_pos = -1;
            m_level = 0;
            en_run  = 0;
        end else begin
            bit s_lvl, s_rise, s_fall, p_rise, m_lvl;
            s_lvl  = sel_h[1];
            s_rise = sel_h[1] && !sel_h[2];
            s_fall = !sel_h[1] && sel_h[2];
            p_rise = pul_h[1] && !pul_h[2];
            m_lvl  = mod_h[1];
            en_run = (m_level != 0) ? en_run + 1 : 0;
            if (!m_lvl) begin
                tok_pos = -1;
                m_level = s_lvl ? 0 : 7;
            end else if (s_rise) begin
                m_level = (tok_pos >= 1 && tok_pos <= 7) ? tok_pos : 0;
                tok_pos = -1;
            end else if (s_fall) begin
                tok_pos = 0;
            end else if (p_rise && !s_lvl && tok_pos >= 0 && tok_pos < 8) begin
                tok_pos = tok_pos + 1;
            end
            sel_h.push_front(sel_n); void'(sel_h.pop_back());
            pul_h.push_front(pulse); void'(pul_h.pop_back());
            mod_h.push_front(mode);  void'(mod_h.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            chk("R2 step code model", code, m_level);
            chk("R5 enable model", en, (m_level != 0));
            chk("R6 settled model", settled, (en_run > S));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input int n);
        sel_n = 1'b0;
        tick(4);
        for (int i = 0; i < n; i++) begin
            pulse = 1'b1; tick(2);
            pulse = 1'b0; tick(2);
        end
        sel_n = 1'b1;
        tick(4);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        chk("R1 reset code", code, 0);
        chk("R1 reset enable", en, 0);
        chk("R1 reset settled", settled, 0);

        send_frame(3);
        chk("R2 three pulses", code, 3);
        chk("R5 enable on", en, 1);
        chk("R6 not yet settled", settled, 0);
        tick(S + 4);
        chk("R6 settled after delay", settled, 1);

        send_frame(5);
        chk("R2 five pulses", code, 5);
        chk("R6 no restart on step change", settled, 1);

        sel_n = 1'b0; tick(4);
        for (int i = 0; i < 2; i++) begin pulse = 1'b1; tick(2); pulse = 1'b0; tick(2); end
        chk("R4 code held mid frame", code, 5);
        for (int i = 0; i < 4; i++) begin pulse = 1'b1; tick(2); pulse = 1'b0; tick(2); end
        sel_n = 1'b1; tick(4);
        chk("R2 six pulses", code, 6);

        for (int i = 0; i < 3; i++) begin pulse = 1'b1; tick(2); pulse = 1'b0; tick(2); end
        chk("R4 pulses with select high ignored", code, 6);

        send_frame(7);
        chk("R2 seven pulses", code, 7);
        send_frame(8);
        chk("R3 eight pulses overflow", code, 0);
        chk("R3 overflow disables", en, 0);
        chk("R6 settled dropped", settled, 0);
        send_frame(11);
        chk("R3 eleven pulses overflow", code, 0);

        send_frame(1);
        chk("R2 one pulse", code, 1);
        send_frame(0);
        chk("R9 empty frame shuts down", code, 0);

        sel_n = 1'b0; tick(4);
        for (int i = 0; i < 2; i++) begin pulse = 1'b1; tick(2); pulse = 1'b0; tick(2); end
        sel_n = 1'b1;
        tick(1); chk("R8 latency edge1", code, 0);
        tick(1); chk("R8 latency edge2", code, 0);
        tick(1); chk("R8 latency edge3", code, 2);
        tick(S + 4);

        mode = 1'b0; tick(4);
        chk("R7 direct idle off", code, 0);
        sel_n = 1'b0; tick(4);
        chk("R7 direct select low full", code, 7);
        for (int i = 0; i < 3; i++) begin pulse = 1'b1; tick(2); pulse = 1'b0; tick(2); end
        chk("R7 pulses ignored in direct", code, 7);
        sel_n = 1'b1; tick(4);
        chk("R7 direct select high off", code, 0);
        for (int i = 0; i < 4; i++) begin
            sel_n = 1'b0; tick(6);
            sel_n = 1'b1; tick(3);
        end
        tick(4);
        chk("R7 pwm ends off", code, 0);

        mode = 1'b1; tick(4);
        send_frame(4);
        chk("R2 counted after direct", code, 4);
        tick(S + 4);
        chk("R6 settled final", settled, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule